// File: doc/BRIEF.md
# Per-Channel Strip Hit Finder

This block serves a single readout channel of a silicon strip detector. A multiplexed front-end sends, per triggered event, a short digital header followed by one digitized sample for each strip. The block throws away the header, stores the strip samples, and then searches them for strips whose signal stands clear of that strip's baseline. Each strip has a pedestal and a threshold in a small on-block memory. The host loads this memory while the channel is quiet.

The block makes two passes over each event. In the capture pass, every strip sample is written into one half of a two-bank frame store. In the same pass two sums build up: one over the clipped samples, where a sample above its pedestal is replaced by the pedestal, and one over all pedestals. When the last strip arrives, their scaled difference gives a common-mode offset for that event. This offset is added to every pedestal. In the scan pass, the stored strips are visited in ascending order. Each strip's sample is compared with its corrected pedestal plus threshold. Every strip above that level produces a hit record with the strip index, its own sample and the samples on either side. A one-cycle end-of-event pulse follows the last record.

The scan of one event runs in the other bank while the next event is being captured, so events may follow one another with no gap. Capture states: CAP_IDLE waits for the frame-start marker and goes to CAP_HDR. CAP_HDR counts header samples and, on the last one, goes to CAP_STRIP. CAP_STRIP stores the strips and returns to CAP_IDLE on the final strip. Scan states: SCN_IDLE goes to SCN_RUN when a capture completes. SCN_RUN visits every strip and, after the final strip, goes to SCN_END. SCN_END raises the end pulse and returns to SCN_IDLE.

Top module: `strip_hit_finder`

## Requirements
- R1: After reset, hit_valid and evt_end are low, and they stay low until a frame has been captured.
- R2: After a frame-start marker, the first HDR_LEN cycles with in_valid high are header and are discarded. The next NSTRIP valid samples are strips 0 to NSTRIP-1 in order. Cycles with in_valid low do not advance either count.
- R3: The event offset is floor(A/NSTRIP) - floor(P/NSTRIP). P is the sum of all strip pedestals. A is the sum over all strips of the sample when the sample is at or below its pedestal, and of the pedestal otherwise. The offset is never positive.
- R4: Strip k is a hit exactly when its sample, as an unsigned value, is strictly greater than the signed value pedestal[k] + offset + threshold[k]. A sample equal to that level is not a hit.
- R5: A hit record gives hit_strip = k, hit_center = sample k, hit_left = sample k-1 and hit_right = sample k+1. A neighbour that falls outside strips 0 to NSTRIP-1 is reported as 0.
- R6: Hit records come out one per cycle with hit_valid high, in ascending strip order, with at most one record per strip per event.
- R7: evt_end is a single-cycle pulse. It appears NSTRIP+1 clock edges after the edge that accepted the final strip sample, after all hit records of that event. It is also produced when the event has no hits.
- R8: A frame-start marker may arrive in the cycle right after the final strip sample of the previous frame. Both frames are then processed correctly and in order.
- R9: A write with cfg_we high changes the pedestal and threshold at cfg_addr only while no frame is being captured and no scan is running. At any other time it has no effect.
- R10: While a frame is being captured, a frame-start marker is ignored. In the idle state, in_valid without a marker is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Frame-start marker, one cycle before the header |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW | Digitized sample |
| cfg_we | input | 1 | Calibration write enable |
| cfg_addr | input | log2(NSTRIP) | Strip index for the calibration write |
| cfg_ped | input | DW | Pedestal value to write |
| cfg_thr | input | TW | Threshold value to write |
| hit_valid | output | 1 | A hit record is present |
| hit_strip | output | log2(NSTRIP) | Strip index of the hit |
| hit_center | output | DW | Sample of the hit strip |
| hit_left | output | DW | Sample of strip index minus one, or 0 |
| hit_right | output | DW | Sample of strip index plus one, or 0 |
| evt_end | output | 1 | End-of-event pulse |

## Verification
The first pattern is a flat frame with every sample equal to its pedestal. It gives an offset of zero and no hits, so any false hit from the compare or the summing shows up alone. The second pattern lowers the baseline by a fixed amount. On top of it sit hits at strips 0, NSTRIP/2 and NSTRIP-1, plus an adjacent pair placed exactly at the corrected level and one count above it. This pattern separates a correct offset from an uncorrected one, a strict compare from a non-strict one, and checks the zeroing of neighbours at the edges. A ramp-like pattern is sent with gaps in the strobe, stray strobes while idle and a stray marker in the middle of the strips. Any slip in header skipping or strip counting then shows up as shifted hit indices. Finally, two different frames are sent back to back, and calibration writes are issued during capture, during the scan and while idle, to show which writes take effect.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_HDR,
        CAP_STRIP
    } cap_state_t;

    typedef enum logic [1:0] {
        SCN_IDLE,
        SCN_RUN,
        SCN_END
    } scn_state_t;

endpackage

// File: rtl/shf_cal_mem.sv
module shf_cal_mem #(
    parameter int NSTRIP = 128,
    parameter int DW     = 10,
    parameter int TW     = 8,
    localparam int IW    = $clog2(NSTRIP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_ped,
    input  logic [TW-1:0] cfg_thr,
    input  logic [IW-1:0] ra_addr,
    output logic [DW-1:0] ra_ped,
    input  logic [IW-1:0] rb_addr,
    output logic [DW-1:0] rb_ped,
    output logic [TW-1:0] rb_thr
);

    logic [DW-1:0] ped_q [NSTRIP];
    logic [TW-1:0] thr_q [NSTRIP];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTRIP; i++) begin
                ped_q[i] <= '0;
                thr_q[i] <= '0;
            end
        end else if (cfg_we && !busy) begin
            ped_q[cfg_addr] <= cfg_ped;
            thr_q[cfg_addr] <= cfg_thr;
        end
    end

    assign ra_ped = ped_q[ra_addr];
    assign rb_ped = ped_q[rb_addr];
    assign rb_thr = thr_q[rb_addr];

    AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && busy) |=> ped_q[$past(cfg_addr)] == $past(ped_q[cfg_addr])); // R9

endmodule

// File: rtl/shf_frame_buf.sv
module shf_frame_buf #(
    parameter int NSTRIP = 128,
    parameter int DW     = 10,
    localparam int IW    = $clog2(NSTRIP)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wbank,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rbank,
    input  logic [IW-1:0] ra_c,
    input  logic [IW-1:0] ra_l,
    input  logic [IW-1:0] ra_r,
    output logic [DW-1:0] rd_c,
    output logic [DW-1:0] rd_l,
    output logic [DW-1:0] rd_r
);

    localparam int NBANK = 2;

    logic [DW-1:0] bank_c [NBANK];
    logic [DW-1:0] bank_l [NBANK];
    logic [DW-1:0] bank_r [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DW-1:0] mem [NSTRIP];

        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(b))) begin
                mem[waddr] <= wdata;
            end
        end

        assign bank_c[b] = mem[ra_c];
        assign bank_l[b] = mem[ra_l];
        assign bank_r[b] = mem[ra_r];
    end

    assign rd_c = bank_c[rbank];
    assign rd_l = bank_l[rbank];
    assign rd_r = bank_r[rbank];

endmodule

// File: rtl/shf_capture.sv
module shf_capture
    import shf_pkg::*;
#(
    parameter int NSTRIP  = 128,
    parameter int HDR_LEN = 12,
    parameter int DW      = 10,
    localparam int IW     = $clog2(NSTRIP),
    localparam int CMW    = DW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frm_start,
    input  logic           in_valid,
    input  logic [DW-1:0]  in_data,
    input  logic [DW-1:0]  ped,
    output logic [IW-1:0]  strip_idx,
    output logic           buf_we,
    output logic           buf_bank,
    output logic           frame_done,
    output logic [CMW-1:0] cm_o,
    output logic           active
);

    localparam int HCW = $clog2(HDR_LEN + 1);
    localparam int SH  = $clog2(NSTRIP);
    localparam int AW  = DW + IW + 2;
    localparam logic [HCW-1:0] HLAST = HCW'(HDR_LEN - 1);
    localparam logic [IW-1:0]  SLAST = IW'(NSTRIP - 1);

    cap_state_t state, state_nx;
    logic [HCW-1:0]       hcnt;
    logic [IW-1:0]        scnt;
    logic                 bank;
    logic signed [AW-1:0] acc, psum;
    logic signed [AW-1:0] acc_n, ps_n, cm_full;
    logic [DW-1:0]        contrib;

    // clipped contribution: data at or below pedestal, pedestal otherwise
    assign contrib = (in_data <= ped) ? in_data : ped;
    assign acc_n   = acc  + $signed({{(AW-DW){1'b0}}, contrib});
    assign ps_n    = psum + $signed({{(AW-DW){1'b0}}, ped});
    assign cm_full = (acc_n >>> SH) - (ps_n >>> SH);

    assign strip_idx  = scnt;
    assign buf_bank   = bank;
    assign buf_we     = (state == CAP_STRIP) && in_valid;
    assign frame_done = buf_we && (scnt == SLAST);
    assign cm_o       = cm_full[CMW-1:0];
    assign active     = (state != CAP_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            CAP_IDLE:  if (frm_start)                    state_nx = CAP_HDR;
            CAP_HDR:   if (in_valid && hcnt == HLAST)    state_nx = CAP_STRIP;
            CAP_STRIP: if (frame_done)                   state_nx = CAP_IDLE;
            default:                                     state_nx = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            scnt <= '0;
            bank <= 1'b0;
            acc  <= '0;
            psum <= '0;
        end else begin
            unique case (state)
                CAP_IDLE: begin
                    if (frm_start) begin
                        hcnt <= '0;
                        scnt <= '0;
                        acc  <= '0;
                        psum <= '0;
                    end
                end
                CAP_HDR: begin
                    if (in_valid) begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                CAP_STRIP: begin
                    if (in_valid) begin
                        acc  <= acc_n;
                        psum <= ps_n;
                        scnt <= scnt + 1'b1;
                        if (scnt == SLAST) begin
                            bank <= ~bank;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_CM_NOT_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $signed(cm_o) <= 0); // R3
    AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> buf_bank != $past(buf_bank)); // R8
    AST_MARKER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_STRIP && frm_start && !frame_done) |=> state == CAP_STRIP); // R10

endmodule

// File: rtl/shf_scanner.sv
module shf_scanner
    import shf_pkg::*;
#(
    parameter int NSTRIP = 128,
    parameter int DW     = 10,
    parameter int TW     = 8,
    localparam int IW    = $clog2(NSTRIP),
    localparam int CMW   = DW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           start_bank,
    input  logic [CMW-1:0] start_cm,
    input  logic [DW-1:0]  ped,
    input  logic [TW-1:0]  thr,
    input  logic [DW-1:0]  rd_c,
    input  logic [DW-1:0]  rd_l,
    input  logic [DW-1:0]  rd_r,
    output logic           rd_bank,
    output logic [IW-1:0]  ra_c,
    output logic [IW-1:0]  ra_l,
    output logic [IW-1:0]  ra_r,
    output logic           busy,
    output logic           hit_valid,
    output logic [IW-1:0]  hit_strip,
    output logic [DW-1:0]  hit_center,
    output logic [DW-1:0]  hit_left,
    output logic [DW-1:0]  hit_right,
    output logic           evt_end
);

    localparam int LW = DW + 3;
    localparam logic [IW-1:0] SLAST = IW'(NSTRIP - 1);

    scn_state_t state, state_nx;
    logic [IW-1:0]        k;
    logic                 bank_q;
    logic [CMW-1:0]       cm_q;
    logic signed [LW-1:0] level, samp_s;
    logic [DW-1:0]        left_v, right_v;
    logic                 is_hit;

    assign ra_c    = k;
    assign ra_l    = k - 1'b1;
    assign ra_r    = k + 1'b1;
    assign rd_bank = bank_q;
    assign busy    = (state != SCN_IDLE);

    always_comb begin
        left_v  = (k == '0)    ? '0 : rd_l;
        right_v = (k == SLAST) ? '0 : rd_r;
        level   = $signed({3'b000, ped})
                + $signed({{(LW-CMW){cm_q[CMW-1]}}, cm_q})
                + $signed({{(LW-TW){1'b0}}, thr});
        samp_s  = $signed({3'b000, rd_c});
        is_hit  = samp_s > level;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SCN_IDLE: if (start)        state_nx = SCN_RUN;
            SCN_RUN:  if (k == SLAST)   state_nx = SCN_END;
            SCN_END:                    state_nx = SCN_IDLE;
            default:                    state_nx = SCN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SCN_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k      <= '0;
            bank_q <= 1'b0;
            cm_q   <= '0;
        end else if (state == SCN_IDLE && start) begin
            k      <= '0;
            bank_q <= start_bank;
            cm_q   <= start_cm;
        end else if (state == SCN_RUN) begin
            k <= k + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid  <= 1'b0;
            hit_strip  <= '0;
            hit_center <= '0;
            hit_left   <= '0;
            hit_right  <= '0;
            evt_end    <= 1'b0;
        end else begin
            hit_valid <= (state == SCN_RUN) && is_hit;
            evt_end   <= (state == SCN_END);
            if (state == SCN_RUN && is_hit) begin
                hit_strip  <= k;
                hit_center <= rd_c;
                hit_left   <= left_v;
                hit_right  <= right_v;
            end
        end
    end

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state == SCN_IDLE); // R8
    AST_EDGE_LEFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_strip == '0) |-> hit_left == '0); // R5
    AST_EDGE_RIGHT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_strip == SLAST) |-> hit_right == '0); // R5
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && $past(hit_valid)) |-> hit_strip == IW'($past(hit_strip) + 1'b1)); // R6
    AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_end |=> !evt_end && !hit_valid); // R7

endmodule

// File: rtl/strip_hit_finder.sv
module strip_hit_finder #(
    parameter int NSTRIP  = 128,
    parameter int HDR_LEN = 12,
    parameter int DW      = 10,
    parameter int TW      = 8,
    localparam int IW     = $clog2(NSTRIP),
    localparam int CMW    = DW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_start,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_ped,
    input  logic [TW-1:0] cfg_thr,
    output logic          hit_valid,
    output logic [IW-1:0] hit_strip,
    output logic [DW-1:0] hit_center,
    output logic [DW-1:0] hit_left,
    output logic [DW-1:0] hit_right,
    output logic          evt_end
);

    logic [IW-1:0]  cap_idx;
    logic           cap_we, cap_bank, cap_done, cap_active;
    logic [CMW-1:0] cap_cm;
    logic [DW-1:0]  ped_a, ped_b;
    logic [TW-1:0]  thr_b;
    logic           scn_busy, scn_bank;
    logic [IW-1:0]  ra_c, ra_l, ra_r;
    logic [DW-1:0]  rd_c, rd_l, rd_r;

    shf_cal_mem #(.NSTRIP(NSTRIP), .DW(DW), .TW(TW)) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (cap_active || scn_busy),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_ped  (cfg_ped),
        .cfg_thr  (cfg_thr),
        .ra_addr  (cap_idx),
        .ra_ped   (ped_a),
        .rb_addr  (ra_c),
        .rb_ped   (ped_b),
        .rb_thr   (thr_b)
    );

    shf_capture #(.NSTRIP(NSTRIP), .HDR_LEN(HDR_LEN), .DW(DW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_start  (frm_start),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .ped        (ped_a),
        .strip_idx  (cap_idx),
        .buf_we     (cap_we),
        .buf_bank   (cap_bank),
        .frame_done (cap_done),
        .cm_o       (cap_cm),
        .active     (cap_active)
    );

    shf_frame_buf #(.NSTRIP(NSTRIP), .DW(DW)) u_buf (
        .clk   (clk),
        .we    (cap_we),
        .wbank (cap_bank),
        .waddr (cap_idx),
        .wdata (in_data),
        .rbank (scn_bank),
        .ra_c  (ra_c),
        .ra_l  (ra_l),
        .ra_r  (ra_r),
        .rd_c  (rd_c),
        .rd_l  (rd_l),
        .rd_r  (rd_r)
    );

    shf_scanner #(.NSTRIP(NSTRIP), .DW(DW), .TW(TW)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cap_done),
        .start_bank (cap_bank),
        .start_cm   (cap_cm),
        .ped        (ped_b),
        .thr        (thr_b),
        .rd_c       (rd_c),
        .rd_l       (rd_l),
        .rd_r       (rd_r),
        .rd_bank    (scn_bank),
        .ra_c       (ra_c),
        .ra_l       (ra_l),
        .ra_r       (ra_r),
        .busy       (scn_busy),
        .hit_valid  (hit_valid),
        .hit_strip  (hit_strip),
        .hit_center (hit_center),
        .hit_left   (hit_left),
        .hit_right  (hit_right),
        .evt_end    (evt_end)
    );

endmodule

// File: tb/sim_strip_hit_finder.sv
module sim_strip_hit_finder;

    localparam int N  = 128;
    localparam int H  = 12;
    localparam int DW = 10;
    localparam int TW = 8;
    localparam int IW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frm_start = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_ped = '0;
    logic [TW-1:0] cfg_thr = '0;
    logic          hit_valid, evt_end;
    logic [IW-1:0] hit_strip;
    logic [DW-1:0] hit_center, hit_left, hit_right;

    always #4 clk = ~clk;

    strip_hit_finder #(.NSTRIP(N), .HDR_LEN(H), .DW(DW), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .in_valid(in_valid),
        .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_ped(cfg_ped),
        .cfg_thr(cfg_thr), .hit_valid(hit_valid), .hit_strip(hit_strip),
        .hit_center(hit_center), .hit_left(hit_left), .hit_right(hit_right),
        .evt_end(evt_end)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int ped_m [N];
    int thr_m [N];
    int fa [N];
    int fb [N];
    int ex_s [512], ex_c [512], ex_l [512], ex_r [512];
    int ex_n, ex_end [16];
    int gt_s [512], gt_c [512], gt_l [512], gt_r [512];
    int gt_n, end_n, end_at [16], end_cyc [16];
    int last_cyc [16], fr_n;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (hit_valid && gt_n < 512) begin
                gt_s[gt_n] = hit_strip;
                gt_c[gt_n] = hit_center;
                gt_l[gt_n] = hit_left;
                gt_r[gt_n] = hit_right;
                gt_n++;
            end
            if (evt_end && end_n < 16) begin
                end_at[end_n]  = gt_n;
                end_cyc[end_n] = cyc;
                end_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int smp(input int which, input int k);
        return (which != 0) ? fb[k] : fa[k];
    endfunction

    function automatic int cm_of(input int which);
        int a = 0;
        int p = 0;
        for (int k = 0; k < N; k++) begin
            a += (smp(which, k) <= ped_m[k]) ? smp(which, k) : ped_m[k];
            p += ped_m[k];
        end
        return a / N - p / N;
    endfunction

    task automatic add_expected(input int which);
        int cm = cm_of(which);
        for (int k = 0; k < N; k++) begin
            if (smp(which, k) > ped_m[k] + cm + thr_m[k]) begin
                ex_s[ex_n] = k;
                ex_c[ex_n] = smp(which, k);
                ex_l[ex_n] = (k > 0) ? smp(which, k - 1) : 0;
                ex_r[ex_n] = (k < N - 1) ? smp(which, k + 1) : 0;
                ex_n++;
            end
        end
        ex_end[fr_n] = ex_n;
    endtask

    task automatic start_test();
        gt_n = 0; end_n = 0; ex_n = 0; fr_n = 0;
    endtask

    task automatic cfg_write(input int a, input int p, input int t);
        cfg_we = 1'b1; cfg_addr = IW'(a); cfg_ped = DW'(p); cfg_thr = TW'(t);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // entered and left 1 time unit after a rising edge
    task automatic send_frame(input int which, input bit gaps, input bit junk,
                              input bit stray, input int cfg_mid);
        add_expected(which);
        if (junk) begin
            for (int j = 0; j < 3; j++) begin
                in_valid = 1'b1; in_data = DW'(900 + j);
                @(posedge clk); #1;
            end
        end
        in_valid = 1'b0; frm_start = 1'b1;
        @(posedge clk); #1;
        frm_start = 1'b0;
        for (int h = 0; h < H; h++) begin
            if (gaps && (h % 3 == 0)) begin
                in_valid = 1'b0; @(posedge clk); #1;
            end
            in_valid = 1'b1; in_data = DW'(1000 - h * 7);
            @(posedge clk); #1;
        end
        for (int k = 0; k < N; k++) begin
            if (gaps && (k % 5 == 2)) begin
                in_valid = 1'b0; in_data = 10'h3FF; @(posedge clk); #1;
            end
            in_valid = 1'b1; in_data = DW'(smp(which, k));
            frm_start = stray && (k == 50);
            if (cfg_mid >= 0 && k == 30) begin
                cfg_we = 1'b1; cfg_addr = IW'(cfg_mid); cfg_ped = '0; cfg_thr = '0;
            end
            @(posedge clk); #1;
            frm_start = 1'b0; cfg_we = 1'b0;
        end
        in_valid = 1'b0;
        last_cyc[fr_n] = cyc;
        fr_n++;
    endtask

    task automatic wait_ends(input int n);
        int t = 0;
        while (end_n < n && t < 3000) begin
            @(negedge clk); t++;
        end
        chk(end_n >= n, "R7", "end-of-event pulses seen", end_n, n);
        repeat (4) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic compare(input string req);
        chk(gt_n == ex_n, req, "hit record count", gt_n, ex_n);
        for (int i = 0; i < gt_n && i < ex_n; i++) begin
            chk(gt_s[i] == ex_s[i], req, $sformatf("record %0d strip", i), gt_s[i], ex_s[i]);
            chk(gt_c[i] == ex_c[i], req, $sformatf("record %0d center", i), gt_c[i], ex_c[i]);
            chk(gt_l[i] == ex_l[i], "R5", $sformatf("record %0d left", i), gt_l[i], ex_l[i]);
            chk(gt_r[i] == ex_r[i], "R5", $sformatf("record %0d right", i), gt_r[i], ex_r[i]);
        end
        for (int j = 0; j < fr_n && j < end_n; j++) begin
            chk(end_cyc[j] - last_cyc[j] == N + 1, "R7", "end pulse latency",
                end_cyc[j] - last_cyc[j], N + 1);
            chk(end_at[j] == ex_end[j], "R7", "records before end pulse", end_at[j], ex_end[j]);
        end
        chk(end_n == fr_n, "R7", "one end pulse per frame", end_n, fr_n);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(hit_valid == 1'b0, "R1", "hit_valid after reset", int'(hit_valid), 0);
        chk(evt_end == 1'b0, "R1", "evt_end after reset", int'(evt_end), 0);
        chk(gt_n == 0 && end_n == 0, "R1", "activity after reset", gt_n + end_n, 0);
        @(posedge clk); #1;
    endtask

    task automatic t_load();
        for (int k = 0; k < N; k++) begin
            ped_m[k] = 100 + (k % 7) * 3;
            thr_m[k] = 20 + (k % 4);
            cfg_write(k, ped_m[k], thr_m[k]);
        end
    endtask

    task automatic t_flat();
        start_test();
        for (int k = 0; k < N; k++) fa[k] = ped_m[k];
        chk(cm_of(0) == 0, "R3", "model offset of flat frame", cm_of(0), 0);
        send_frame(0, 1'b0, 1'b0, 1'b0, -1);
        wait_ends(1);
        compare("R7");
    endtask

    task automatic t_edges();
        int cm;
        start_test();
        for (int k = 0; k < N; k++) fa[k] = ped_m[k] - 8;
        fa[0] = 900; fa[64] = 700; fa[127] = 850;
        fa[40] = ped_m[40] + 1; fa[41] = ped_m[41] + 1;
        cm = cm_of(0);
        chk(cm < 0, "R3", "model offset negative", cm, -1);
        fa[40] = ped_m[40] + cm + thr_m[40];
        fa[41] = ped_m[41] + cm + thr_m[41] + 1;
        send_frame(0, 1'b0, 1'b0, 1'b0, -1);
        wait_ends(1);
        chk(ex_n == 4, "R4", "model hits at boundary", ex_n, 4);
        compare("R4");
    endtask

    task automatic t_gaps();
        start_test();
        for (int k = 0; k < N; k++) fa[k] = ped_m[k] + ((k * 37) % 61) - 15;
        send_frame(0, 1'b1, 1'b1, 1'b1, -1);
        wait_ends(1);
        compare("R2");
        chk(gt_n > 3, "R10", "hits found with stray marker", gt_n, 4);
    endtask

    task automatic t_b2b();
        start_test();
        for (int k = 0; k < N; k++) begin
            fa[k] = ped_m[k] + ((k * 13) % 50) - 10;
            fb[k] = (k % 9 == 4) ? 600 + k : ped_m[k] - 3;
        end
        send_frame(0, 1'b0, 1'b0, 1'b0, -1);
        send_frame(1, 1'b0, 1'b0, 1'b0, -1);
        wait_ends(2);
        compare("R8");
        compare("R6");
    endtask

    task automatic t_cfg();
        int old33;
        start_test();
        for (int k = 0; k < N; k++) fa[k] = ped_m[k];
        send_frame(0, 1'b0, 1'b0, 1'b0, 10);
        cfg_write(20, 0, 0);
        wait_ends(1);
        compare("R9");
        start_test();
        send_frame(0, 1'b0, 1'b0, 1'b0, -1);
        wait_ends(1);
        compare("R9");
        start_test();
        old33 = ped_m[33];
        ped_m[33] = old33 - 50;
        cfg_write(33, ped_m[33], thr_m[33]);
        send_frame(0, 1'b0, 1'b0, 1'b0, -1);
        wait_ends(1);
        chk(ex_n == 1, "R9", "model hit after idle write", ex_n, 1);
        compare("R9");
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        start_test();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_load();
        t_flat();
        t_edges();
        t_gaps();
        t_b2b();
        t_cfg();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule